// File: doc/BRIEF.md
# Two-Slot Recent Data Translation Cache

This block sits in front of a full data TLB and remembers the two translations it used most recently. A data access presents its virtual address, its size in bytes, an 8-bit address-space identifier (ASI) and the current 64-bit translation state word. If one of the two remembered translations covers the access, the block returns the physical address in the same cycle and raises a hit flag. The full TLB lookup can then be skipped.

When the block misses, the full TLB resolves the access and writes the result back as a fill. A fill carries the backing-TLB index of the entry, the range start and length, and the physical page base. A fill of an index that is not already held pushes the newest entry to the front and drops the older one. Any change to the backing TLB (insert, demap or invalidate) arrives on one change pulse, and that pulse makes the whole cache stale.

An implicit access (one whose ASI equals the implicit code) made in hypervisor mode needs no translation. The block returns the virtual address cut to the physical width and flags the result as a bypass.

Top module: `xlat_mru2`

## Requirements
- R1: After reset both slots are empty and the cache is marked stale, so no lookup hits except through the bypass of R2.
- R2: When `lk_asi` equals the implicit code (parameter `IMPLICIT_ASI`) and bit 0 of `lk_state` is 1, `hit` and `bypass` are 1 and `pa` equals the low 40 bits of `lk_va`, whatever the cache holds.
- R3: A non-bypass hit requires the cache-valid flag to be set and the state word captured at the last fill to equal `lk_state` exactly.
- R4: A slot matches only if it is occupied and its stored ASI equals `lk_asi`.
- R5: A slot's range test passes when start < va + size and start + length >= va, both compared without wraparound.
- R6: On a hit, `pa` is the slot's page base with its low log2(length) bits cleared, ORed with the same low bits of `lk_va` (length is a power of two).
- R7: When both slots match, slot 0, the newer one, supplies `pa`.
- R8: A fill whose index is held in neither slot moves slot 0 into slot 1 and writes the new entry into slot 0. The entry that was in slot 1 is dropped.
- R9: A fill whose index is already held leaves both slots' contents unchanged.
- R10: A fill whose ASI equals the implicit code stores ASI 0 in slot 0.
- R11: A pulse on `tlb_change` clears the cache-valid flag. If it arrives in the same cycle as a fill, the flag is still clear afterwards.
- R12: A fill without a change pulse sets the cache-valid flag and captures `fl_state` as the state word for all later matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_va | input | 48 | Lookup virtual address |
| lk_size | input | 4 | Access size in bytes |
| lk_asi | input | 8 | Lookup address-space identifier |
| lk_state | input | 64 | Current translation state word (bit 0 = hypervisor) |
| fl_en | input | 1 | Fill strobe from the full TLB lookup |
| fl_idx | input | 6 | Backing-TLB index of the filled entry |
| fl_asi | input | 8 | ASI of the access that caused the fill |
| fl_state | input | 64 | State word in force for the fill |
| fl_vstart | input | 48 | Virtual range start of the entry |
| fl_vlen | input | 48 | Virtual range length (power of two, also the page size) |
| fl_pbase | input | 40 | Physical page base of the entry |
| tlb_change | input | 1 | Pulse on any TLB insert, demap or invalidate |
| hit | output | 1 | Fast translation available |
| bypass | output | 1 | Hit came from the hypervisor implicit bypass |
| pa | output | 40 | Physical address |

## Verification
A fill and a TLB change pulse can land on the same clock edge. In that case the flush must win even though the slots still shift. The bench raises `fl_en` and `tlb_change` together on one edge and then checks that a lookup covered by the new entry misses. A later plain fill must make the cache usable again. The second overlap is a bypass lookup while the cache holds an entry for the same address. That lookup must return the truncated virtual address and not the cached page.

// File: rtl/xlat_pkg.sv
// Shared widths and the slot record for the recent-translation cache.
// Assumes a 48-bit virtual and 40-bit physical address space.
package xlat_pkg;
    localparam int VA_W  = 48;
    localparam int PA_W  = 40;
    localparam int ASI_W = 8;
    localparam int IDX_W = 6;
    localparam int ST_W  = 64;
    localparam int SZ_W  = 4;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [ASI_W-1:0] asi;
        logic [VA_W-1:0]  vstart;
        logic [VA_W-1:0]  vlen;
        logic [PA_W-1:0]  pbase;
    } xlat_ent_t;
endpackage

// File: rtl/xlat_slot.sv
// Match and address composition for one held translation.
// Assumes vlen is a nonzero power of two; range test uses one extra bit.
module xlat_slot
    import xlat_pkg::*;
(
    input  xlat_ent_t        ent,
    input  logic [VA_W-1:0]  va,
    input  logic [SZ_W-1:0]  size,
    input  logic [ASI_W-1:0] asi,
    output logic             match,
    output logic [PA_W-1:0]  pa
);
    logic [VA_W:0]   acc_end;
    logic [VA_W:0]   rng_end;
    logic            in_rng;
    logic [PA_W-1:0] off_mask;

    // Range test against the access span.
    always_comb begin
        acc_end = {1'b0, va} + (VA_W+1)'(size);
        rng_end = {1'b0, ent.vstart} + {1'b0, ent.vlen};
        in_rng  = ({1'b0, ent.vstart} < acc_end) && (rng_end >= {1'b0, va});
        match   = ent.vld && (ent.asi == asi) && in_rng;
    end

    // Page base merged with the in-page offset.
    always_comb begin
        off_mask = ent.vlen[PA_W-1:0] - 1'b1;
        pa       = (ent.pbase & ~off_mask) | (va[PA_W-1:0] & off_mask);
    end
endmodule

// File: rtl/xlat_store.sv
// Slot storage, move-to-front shift replacement, valid flag and state tag.
// Assumes the caller has already zeroed the ASI of implicit fills.
module xlat_store
    import xlat_pkg::*;
#(
    parameter int N_SLOT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fl_en,
    input  xlat_ent_t       fl_ent,
    input  logic [ST_W-1:0] fl_state,
    input  logic            flush,
    output xlat_ent_t       slot_q [N_SLOT],
    output logic            valid_q,
    output logic [ST_W-1:0] state_q
);
    logic held;

    // Is the filled index already resident in any slot?
    always_comb begin
        held = 1'b0;
        for (int i = 0; i < N_SLOT; i++)
            if (slot_q[i].vld && slot_q[i].idx == fl_ent.idx) held = 1'b1;
    end

    // Front slot takes the new entry on a fresh fill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q[0] <= '0;
        else if (fl_en && !held)
            slot_q[0] <= fl_ent;
    end

    // Older slots shift back by one on a fresh fill.
    for (genvar g = 1; g < N_SLOT; g++) begin : g_shift
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (fl_en && !held)
                slot_q[g] <= slot_q[g-1];
        end
    end

    // Valid flag and state tag; a change pulse overrides a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            state_q <= '0;
        end else if (flush) begin
            valid_q <= 1'b0;
        end else if (fl_en) begin
            valid_q <= 1'b1;
            state_q <= fl_state;
        end
    end

    a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !valid_q);
    a_r12_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && !flush) |=> (valid_q && state_q == $past(fl_state)));
    a_r8_new_to_front: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && !held) |=> (slot_q[0].idx == $past(fl_ent.idx) && slot_q[0].vld));
    a_r9_held_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && held) |=> $stable(slot_q[0]));
endmodule

// File: rtl/xlat_mru2.sv
// Top of the recent data translation cache: hypervisor bypass, state-gated
// priority lookup across the slots, and fill record formation.
// Assumes lookups are combinational and fills land on the next clock edge.
module xlat_mru2
    import xlat_pkg::*;
#(
    parameter int              N_SLOT       = 2,
    parameter logic [ASI_W-1:0] IMPLICIT_ASI = 8'h00,
    parameter int              HPRIV_BIT    = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VA_W-1:0]  lk_va,
    input  logic [SZ_W-1:0]  lk_size,
    input  logic [ASI_W-1:0] lk_asi,
    input  logic [ST_W-1:0]  lk_state,
    input  logic             fl_en,
    input  logic [IDX_W-1:0] fl_idx,
    input  logic [ASI_W-1:0] fl_asi,
    input  logic [ST_W-1:0]  fl_state,
    input  logic [VA_W-1:0]  fl_vstart,
    input  logic [VA_W-1:0]  fl_vlen,
    input  logic [PA_W-1:0]  fl_pbase,
    input  logic             tlb_change,
    output logic             hit,
    output logic             bypass,
    output logic [PA_W-1:0]  pa
);
    xlat_ent_t       fl_ent;
    xlat_ent_t       slot_q [N_SLOT];
    logic            valid_q;
    logic [ST_W-1:0] state_q;
    logic [N_SLOT-1:0] sl_match;
    logic [PA_W-1:0] sl_pa [N_SLOT];
    logic            bypass_c;
    logic            cache_ok;
    logic            any_match;
    logic [PA_W-1:0] sel_pa;

    // Build the fill record; implicit fills are tagged with ASI zero.
    always_comb begin
        fl_ent.vld    = 1'b1;
        fl_ent.idx    = fl_idx;
        fl_ent.asi    = (fl_asi == IMPLICIT_ASI) ? '0 : fl_asi;
        fl_ent.vstart = fl_vstart;
        fl_ent.vlen   = fl_vlen;
        fl_ent.pbase  = fl_pbase;
    end

    xlat_store #(.N_SLOT(N_SLOT)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .fl_en    (fl_en),
        .fl_ent   (fl_ent),
        .fl_state (fl_state),
        .flush    (tlb_change),
        .slot_q   (slot_q),
        .valid_q  (valid_q),
        .state_q  (state_q)
    );

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        xlat_slot u_slot (
            .ent   (slot_q[g]),
            .va    (lk_va),
            .size  (lk_size),
            .asi   (lk_asi),
            .match (sl_match[g]),
            .pa    (sl_pa[g])
        );
    end

    // Pick the lowest-numbered matching slot.
    always_comb begin
        any_match = 1'b0;
        sel_pa    = '0;
        for (int i = N_SLOT-1; i >= 0; i--) begin
            if (sl_match[i]) begin
                any_match = 1'b1;
                sel_pa    = sl_pa[i];
            end
        end
    end

    // Bypass first, then the state-gated cache result.
    always_comb begin
        bypass_c = (lk_asi == IMPLICIT_ASI) && lk_state[HPRIV_BIT];
        cache_ok = valid_q && (state_q == lk_state);
        bypass   = bypass_c;
        hit      = bypass_c || (cache_ok && any_match);
        pa       = bypass_c ? lk_va[PA_W-1:0] : sel_pa;
    end

    a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        ((lk_asi == IMPLICIT_ASI) && lk_state[HPRIV_BIT]) |-> (hit && bypass && pa == lk_va[PA_W-1:0]));
    a_r3_state_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !bypass) |-> (valid_q && state_q == lk_state));
    a_r4_asi_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !bypass) |-> ((slot_q[0].vld && slot_q[0].asi == lk_asi) ||
                              (slot_q[N_SLOT-1].vld && slot_q[N_SLOT-1].asi == lk_asi)));
endmodule

// File: tb/sim_xlat_mru2.sv
module sim_xlat_mru2;
    import xlat_pkg::*;

    localparam logic [ASI_W-1:0] IMP = 8'h80;
    localparam logic [ST_W-1:0]  S1  = 64'h0000_1234_0000_0004;
    localparam logic [ST_W-1:0]  S2  = 64'h0000_5678_0000_0004;
    localparam logic [ST_W-1:0]  HP  = S1 | 64'h1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [VA_W-1:0]  lk_va = '0;
    logic [SZ_W-1:0]  lk_size = '0;
    logic [ASI_W-1:0] lk_asi = '0;
    logic [ST_W-1:0]  lk_state = '0;
    logic             fl_en = 1'b0;
    logic [IDX_W-1:0] fl_idx = '0;
    logic [ASI_W-1:0] fl_asi = '0;
    logic [ST_W-1:0]  fl_state = '0;
    logic [VA_W-1:0]  fl_vstart = '0;
    logic [VA_W-1:0]  fl_vlen = '0;
    logic [PA_W-1:0]  fl_pbase = '0;
    logic             tlb_change = 1'b0;
    logic             hit, bypass;
    logic [PA_W-1:0]  pa;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xlat_mru2 #(.IMPLICIT_ASI(IMP)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_size(lk_size),
        .lk_asi(lk_asi), .lk_state(lk_state), .fl_en(fl_en), .fl_idx(fl_idx),
        .fl_asi(fl_asi), .fl_state(fl_state), .fl_vstart(fl_vstart),
        .fl_vlen(fl_vlen), .fl_pbase(fl_pbase), .tlb_change(tlb_change),
        .hit(hit), .bypass(bypass), .pa(pa)
    );

    function automatic logic [PA_W-1:0] model_pa(logic [PA_W-1:0] base,
                                                 logic [VA_W-1:0] len,
                                                 logic [VA_W-1:0] va);
        logic [PA_W-1:0] m;
        m = len[PA_W-1:0] - 1'b1;
        return (base & ~m) | (va[PA_W-1:0] & m);
    endfunction

    // Drive a lookup at the falling edge and compare the outputs 1 ns later.
    task automatic look(string req, logic [VA_W-1:0] va, logic [SZ_W-1:0] sz,
                        logic [ASI_W-1:0] asi, logic [ST_W-1:0] st,
                        logic e_hit, logic e_bp, logic [PA_W-1:0] e_pa);
        @(negedge clk);
        lk_va = va; lk_size = sz; lk_asi = asi; lk_state = st;
        #1;
        total++;
        if (hit !== e_hit || bypass !== e_bp || (e_hit && pa !== e_pa)) begin
            bad++;
            $display("FAIL %s: hit=%0b bypass=%0b pa=%h expected hit=%0b bypass=%0b pa=%h",
                     req, hit, bypass, pa, e_hit, e_bp, e_pa);
        end
    endtask

    // Present one fill for a single clock edge, with an optional change pulse.
    task automatic fill(logic [IDX_W-1:0] idx, logic [ASI_W-1:0] asi,
                        logic [ST_W-1:0] st, logic [VA_W-1:0] vs,
                        logic [VA_W-1:0] vl, logic [PA_W-1:0] pb, logic chg);
        @(negedge clk);
        fl_en = 1'b1; fl_idx = idx; fl_asi = asi; fl_state = st;
        fl_vstart = vs; fl_vlen = vl; fl_pbase = pb; tlb_change = chg;
        @(negedge clk);
        fl_en = 1'b0; tlb_change = 1'b0;
    endtask

    task automatic pulse_change();
        @(negedge clk);
        tlb_change = 1'b1;
        @(negedge clk);
        tlb_change = 1'b0;
    endtask

    task automatic t_reset();
        look("R1 empty after reset", 48'h10_0000, 4'd4, 8'h05, S1, 1'b0, 1'b0, '0);
        look("R1 empty, zero asi", 48'h0, 4'd1, 8'h00, S1, 1'b0, 1'b0, '0);
    endtask

    task automatic t_bypass();
        look("R2 bypass", 48'hABCD_1234_5678, 4'd8, IMP, HP, 1'b1, 1'b1, 40'hCD_1234_5678);
        look("R2 no hpriv no bypass", 48'hABCD_1234_5678, 4'd8, IMP, S1, 1'b0, 1'b0, '0);
    endtask

    task automatic t_basic();
        fill(6'd3, 8'h05, S1, 48'h10_0000, 48'h2000, 40'hAB_0000_0000, 1'b0);
        look("R6 R12 basic hit", 48'h10_0123, 4'd4, 8'h05, S1, 1'b1, 1'b0,
             model_pa(40'hAB_0000_0000, 48'h2000, 48'h10_0123));
        look("R3 state mismatch", 48'h10_0123, 4'd4, 8'h05, S2, 1'b0, 1'b0, '0);
        look("R4 asi mismatch", 48'h10_0123, 4'd4, 8'h06, S1, 1'b0, 1'b0, '0);
        look("R2 bypass over cached entry", 48'h10_0123, 4'd4, IMP, HP, 1'b1, 1'b1, 40'h00_0010_0123);
    endtask

    task automatic t_range();
        look("R5 below start", 48'h0F_FFFC, 4'd4, 8'h05, S1, 1'b0, 1'b0, '0);
        look("R5 overlap start", 48'h0F_FFFC, 4'd5, 8'h05, S1, 1'b1, 1'b0, 40'hAB_0000_1FFC);
        look("R5 at range end", 48'h10_2000, 4'd4, 8'h05, S1, 1'b1, 1'b0, 40'hAB_0000_0000);
        look("R5 past range end", 48'h10_2001, 4'd4, 8'h05, S1, 1'b0, 1'b0, '0);
    endtask

    task automatic t_replace();
        fill(6'd7, 8'h05, S1, 48'h10_0000, 48'h2000, 40'hCD_0000_0000, 1'b0);
        look("R7 slot0 priority", 48'h10_0010, 4'd4, 8'h05, S1, 1'b1, 1'b0, 40'hCD_0000_0010);
        fill(6'd9, 8'h05, S1, 48'h40_0000, 48'h1000, 40'h11_0000_0000, 1'b0);
        look("R8 new in front", 48'h40_0020, 4'd4, 8'h05, S1, 1'b1, 1'b0, 40'h11_0000_0020);
        look("R8 older kept in slot1", 48'h10_0010, 4'd4, 8'h05, S1, 1'b1, 1'b0, 40'hCD_0000_0010);
        fill(6'd11, 8'h05, S1, 48'h80_0000, 48'h1000, 40'h22_0000_0000, 1'b0);
        look("R8 oldest dropped", 48'h10_0010, 4'd4, 8'h05, S1, 1'b0, 1'b0, '0);
        look("R8 shifted entry kept", 48'h40_0020, 4'd4, 8'h05, S1, 1'b1, 1'b0, 40'h11_0000_0020);
        fill(6'd9, 8'h05, S1, 48'h40_0000, 48'h1000, 40'h33_0000_0000, 1'b0);
        look("R9 held fill no rewrite", 48'h40_0020, 4'd4, 8'h05, S1, 1'b1, 1'b0, 40'h11_0000_0020);
        look("R9 held fill no shift", 48'h80_0040, 4'd4, 8'h05, S1, 1'b1, 1'b0, 40'h22_0000_0040);
    endtask

    task automatic t_flush();
        pulse_change();
        look("R11 change clears", 48'h80_0040, 4'd4, 8'h05, S1, 1'b0, 1'b0, '0);
        fill(6'd20, 8'h05, S1, 48'h80_0000, 48'h1000, 40'h44_0000_0000, 1'b0);
        look("R12 fill revalidates", 48'h80_0040, 4'd4, 8'h05, S1, 1'b1, 1'b0, 40'h44_0000_0040);
        fill(6'd21, 8'h05, S1, 48'h90_0000, 48'h1000, 40'h45_0000_0000, 1'b1);
        look("R11 change beats fill", 48'h90_0010, 4'd4, 8'h05, S1, 1'b0, 1'b0, '0);
        fill(6'd22, 8'h05, S2, 48'hC0_0000, 48'h1000, 40'h55_0000_0000, 1'b0);
        look("R12 new state hit", 48'hC0_0004, 4'd4, 8'h05, S2, 1'b1, 1'b0, 40'h55_0000_0004);
        look("R12 old state miss", 48'hC0_0004, 4'd4, 8'h05, S1, 1'b0, 1'b0, '0);
    endtask

    task automatic t_implicit();
        fill(6'd30, IMP, S1, 48'h200_0000, 48'h1000, 40'h66_0000_0000, 1'b0);
        look("R10 stored as zero asi", 48'h200_0008, 4'd4, 8'h00, S1, 1'b1, 1'b0, 40'h66_0000_0008);
        look("R10 implicit code misses", 48'h200_0008, 4'd4, IMP, S1, 1'b0, 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_basic();
        t_range();
        t_replace();
        t_flush();
        t_implicit();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule